// File: doc/BRIEF.md
# Receive Character Interrupt Controller

This block sits between a serial receiver and the CPU. It holds received characters in a small FIFO, and each entry carries a two-bit condition tag. The block decides when to raise the receive interrupt request. The receiver pushes one character per cycle with `ch_valid`. The CPU pops the head with `rd_stb` and issues 3-bit commands on `cmd_code` with `cmd_valid`.

The `irq_mode` input picks one of four interrupt policies:

- `00`: interrupts off.
- `01`: interrupt on every character.
- `10`: interrupt on the first character only, re-armed by command.
- `11`: interrupt on tagged (special-condition) characters only.

In modes `10` and `11`, a tagged character that reaches the FIFO head freezes the FIFO. The CPU clears it with the error-reset command. The condition tags collect into sticky error bits, together with an overrun bit.

Top module: `rx_irq_ctrl`

## Requirements
- R1: After reset, `rx_avail`=0, `rx_irq`=0, `err_flags`=000 and `rd_data`=0.
- R2: The FIFO keeps first-in first-out order and holds DEPTH entries (default 3). A push into a full FIFO that is not popping in the same cycle drops the character and sets the sticky overrun bit `err_flags[2]`.
- R3: In mode `01`, `rx_irq` equals `rx_avail` in every cycle.
- R4: In mode `10`, the interrupt latches when the first character arrives after reset or after a re-arm, and a read clears it. Later characters raise nothing until the next re-arm.
- R5: Command `100` re-arms mode `10`. If characters are already stored when the command is issued, the interrupt latches on that same edge.
- R6: Command `110` clears all three bits of `err_flags`. The bits otherwise stay set until this command.
- R7: Tag bit 0 (parity) and tag bit 1 (framing/end) of the head character are ORed into `err_flags[0]` and `err_flags[1]` when `rd_stb` reads a non-empty FIFO.
- R8: In modes `10` and `11`, a head entry with a non-zero tag is held. `rd_stb` returns its data but does not advance the FIFO, and `rx_irq` stays high while the entry is held.
- R9: Command `110` issued while a head entry is held removes that entry, whether or not it was read. The next entry then becomes the head.
- R10: In mode `11`, untagged characters never raise `rx_irq`.
- R11: `rd_stb` on an empty FIFO changes nothing, and `rd_data` keeps showing the last character read.
- R12: In mode `01`, a tagged character does not stall the FIFO.
- R13: In mode `00`, `rx_irq` stays low. Command codes other than `100` and `110` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_mode | input | 2 | Interrupt policy select |
| ch_valid | input | 1 | Receiver pushes a character |
| ch_data | input | DW | Character data |
| ch_tag | input | 2 | Condition tag: bit0 parity, bit1 framing/end |
| rd_stb | input | 1 | CPU read of the FIFO head |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 3 | Command code (100 re-arm, 110 error reset) |
| rx_irq | output | 1 | Receive interrupt request |
| rx_avail | output | 1 | FIFO is non-empty |
| rd_data | output | DW | Head data, or the last character read when empty |
| err_flags | output | 3 | Sticky {overrun, framing, parity} |

## Verification
The assertions assume that `irq_mode` is held steady while characters are queued. They also treat an error reset and a push in the same cycle as a case whose overrun outcome is left open. The overrun check assumes the CPU is idle in that cycle. The stimulus changes the mode only when the FIFO is empty or before a reset. It never issues a command together with an overflowing push, and it applies one action per cycle wherever the expected result would otherwise depend on priority.

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl #(
  parameter int DW    = 8,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    irq_mode,
  input  logic          ch_valid,
  input  logic [DW-1:0] ch_data,
  input  logic [1:0]    ch_tag,
  input  logic          rd_stb,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_code,
  output logic          rx_irq,
  output logic          rx_avail,
  output logic [DW-1:0] rd_data,
  output logic [2:0]    err_flags
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [1:0] M_OFF   = 2'b00;
  localparam logic [1:0] M_EVERY = 2'b01;
  localparam logic [1:0] M_FIRST = 2'b10;
  localparam logic [1:0] M_SPEC  = 2'b11;
  localparam logic [2:0] C_ARM   = 3'b100;
  localparam logic [2:0] C_ERST  = 3'b110;

  logic [DW-1:0] dat_q [DEPTH];
  logic [1:0]    tag_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] last_q;
  logic [2:0]    err_q, err_d;
  logic          armed_q, pend_q;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire empty      = (cnt_q == '0);
  wire full       = (cnt_q == CW'(DEPTH));
  wire stall_mode = (irq_mode == M_FIRST) || (irq_mode == M_SPEC);
  wire frozen     = stall_mode && !empty && (|tag_q[rp_q]);
  wire erst       = cmd_valid && (cmd_code == C_ERST);
  wire arm        = cmd_valid && (cmd_code == C_ARM);
  wire rd_hit     = rd_stb && !empty;
  wire pop        = !empty && (frozen ? erst : rd_stb);
  wire push       = ch_valid && (!full || pop);
  wire ovr        = ch_valid && !push;

  always_comb begin
    err_d = erst ? 3'b000 : (err_q | {1'b0, rd_hit ? tag_q[rp_q] : 2'b00});
    if (ovr) err_d[2] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      dat_q[wp_q] <= ch_data;
      tag_q[wp_q] <= ch_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q    <= '0;
      rp_q    <= '0;
      cnt_q   <= '0;
      last_q  <= '0;
      err_q   <= '0;
      armed_q <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      if (push) wp_q <= nxt(wp_q);
      if (pop)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push) - CW'(pop);
      if (rd_hit) last_q <= dat_q[rp_q];
      err_q <= err_d;
      if (irq_mode == M_FIRST) begin
        if ((armed_q || arm) && (!empty || push)) begin
          pend_q  <= 1'b1;
          armed_q <= 1'b0;
        end else begin
          if (arm)    armed_q <= 1'b1;
          if (rd_stb) pend_q  <= 1'b0;
        end
      end else begin
        if (arm) armed_q <= 1'b1;
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (irq_mode)
      M_OFF:   rx_irq = 1'b0;
      M_EVERY: rx_irq = !empty;
      M_FIRST: rx_irq = pend_q || frozen;
      default: rx_irq = frozen;
    endcase
  end

  assign rx_avail  = !empty;
  assign rd_data   = empty ? last_q : dat_q[rp_q];
  assign err_flags = err_q;

endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] irq_mode,
  input logic       ch_valid,
  input logic       rd_stb,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic       rx_irq,
  input logic       rx_avail,
  input logic [2:0] err_flags,
  input logic       frozen,
  input logic       full
);
  wire erst = cmd_valid && (cmd_code == 3'b110);

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (irq_mode == 2'b00) |-> !rx_irq); // R13
  AST_EVERY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) (irq_mode == 2'b01) |-> (rx_irq == rx_avail)); // R3
  AST_HELD_STAYS: assert property (@(posedge clk) disable iff (!rst_n) (frozen && rd_stb && !erst) |=> rx_avail); // R8
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (erst && !ch_valid) |=> (err_flags == 3'b000)); // R6
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n) (ch_valid && full && !rd_stb && !cmd_valid) |=> err_flags[2]); // R2
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (err_flags[2] && !erst) |=> err_flags[2]); // R6
  AST_SPEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (irq_mode == 2'b11 && !frozen) |-> !rx_irq); // R10
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .ch_valid(ch_valid),
  .rd_stb(rd_stb), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .rx_irq(rx_irq), .rx_avail(rx_avail), .err_flags(err_flags),
  .frozen(frozen), .full(full)
);

// File: tb/rx_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rx_irq_ctrl_tb_top;
  localparam int PER = 20;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] irq_mode = 2'b01;
  logic ch_valid = 0, rd_stb = 0, cmd_valid = 0;
  logic [7:0] ch_data = 0;
  logic [1:0] ch_tag = 0;
  logic [2:0] cmd_code = 0;
  logic rx_irq, rx_avail;
  logic [7:0] rd_data;
  logic [2:0] err_flags;
  int checks = 0, fails = 0;

  always #(PER/2) clk = ~clk;

  rx_irq_ctrl dut_i (.clk(clk), .rst_n(rst_n), .irq_mode(irq_mode), .ch_valid(ch_valid),
    .ch_data(ch_data), .ch_tag(ch_tag), .rd_stb(rd_stb), .cmd_valid(cmd_valid),
    .cmd_code(cmd_code), .rx_irq(rx_irq), .rx_avail(rx_avail), .rd_data(rd_data),
    .err_flags(err_flags));

  // {mode, wv, wdata, tag, rd, cv, cmd} -> {irq, avail, rd_data, err}
  localparam int NV = 13;
  localparam logic [30:0] VEC [NV] = '{
    {2'b01,1'b1,8'hA1,2'b00,1'b0,1'b0,3'b000, 1'b1,1'b1,8'hA1,3'b000}, // R3
    {2'b01,1'b1,8'hB2,2'b01,1'b0,1'b0,3'b000, 1'b1,1'b1,8'hA1,3'b000}, // R2
    {2'b01,1'b0,8'h00,2'b00,1'b1,1'b0,3'b000, 1'b1,1'b1,8'hB2,3'b000}, // R12
    {2'b01,1'b0,8'h00,2'b00,1'b1,1'b0,3'b000, 1'b0,1'b0,8'hB2,3'b001}, // R7
    {2'b01,1'b0,8'h00,2'b00,1'b1,1'b0,3'b000, 1'b0,1'b0,8'hB2,3'b001}, // R11
    {2'b01,1'b1,8'hC3,2'b00,1'b0,1'b0,3'b000, 1'b1,1'b1,8'hC3,3'b001},
    {2'b01,1'b1,8'hD4,2'b00,1'b0,1'b0,3'b000, 1'b1,1'b1,8'hC3,3'b001},
    {2'b01,1'b1,8'hE5,2'b00,1'b0,1'b0,3'b000, 1'b1,1'b1,8'hC3,3'b001},
    {2'b01,1'b1,8'hF6,2'b00,1'b0,1'b0,3'b000, 1'b1,1'b1,8'hC3,3'b101}, // R2 overrun
    {2'b01,1'b0,8'h00,2'b00,1'b0,1'b1,3'b110, 1'b1,1'b1,8'hC3,3'b000}, // R6
    {2'b01,1'b0,8'h00,2'b00,1'b0,1'b1,3'b011, 1'b1,1'b1,8'hC3,3'b000}, // R13
    {2'b01,1'b0,8'h00,2'b00,1'b1,1'b0,3'b000, 1'b1,1'b1,8'hD4,3'b000},
    {2'b01,1'b0,8'h00,2'b00,1'b1,1'b0,3'b000, 1'b1,1'b1,8'hE5,3'b000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic outs(input string req, input logic i, input logic a, input logic [7:0] d, input logic [2:0] e);
    chk({req, " irq"}, 32'(rx_irq), 32'(i));
    chk({req, " avail"}, 32'(rx_avail), 32'(a));
    chk({req, " data"}, 32'(rd_data), 32'(d));
    chk({req, " err"}, 32'(err_flags), 32'(e));
  endtask

  task automatic step(input logic [1:0] m, input logic wv, input logic [7:0] wd, input logic [1:0] tg,
                      input logic rd, input logic cv, input logic [2:0] cc);
    irq_mode = m; ch_valid = wv; ch_data = wd; ch_tag = tg;
    rd_stb = rd; cmd_valid = cv; cmd_code = cc;
    @(posedge clk); #1;
    ch_valid = 0; rd_stb = 0; cmd_valid = 0;
  endtask

  task automatic do_reset(input logic [1:0] m);
    irq_mode = m; rst_n = 0;
    @(posedge clk); @(posedge clk); #1;
    rst_n = 1;
    @(posedge clk); #1;
  endtask

  initial begin
    #(PER * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset(2'b01);
    outs("R1", 1'b0, 1'b0, 8'h00, 3'b000);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][30:29], VEC[i][28], VEC[i][27:20], VEC[i][19:18], VEC[i][17], VEC[i][16], VEC[i][15:13]);
      outs($sformatf("R3/vec%0d", i), VEC[i][12], VEC[i][11], VEC[i][10:3], VEC[i][2:0]);
    end
    step(2'b01, 0, 0, 0, 1, 0, 0);
    outs("R11 drain", 1'b0, 1'b0, 8'hE5, 3'b000);

    // first-character mode
    do_reset(2'b10);
    step(2'b10, 1, 8'h11, 0, 0, 0, 0);  outs("R4 first", 1, 1, 8'h11, 0);
    step(2'b10, 1, 8'h22, 0, 0, 0, 0);  outs("R4 second", 1, 1, 8'h11, 0);
    step(2'b10, 0, 0, 0, 1, 0, 0);      outs("R4 read clears", 0, 1, 8'h22, 0);
    step(2'b10, 1, 8'h33, 0, 0, 0, 0);  outs("R4 no irq", 0, 1, 8'h22, 0);
    step(2'b10, 0, 0, 0, 0, 1, 3'b100); outs("R5 rearm stored", 1, 1, 8'h22, 0);
    step(2'b10, 0, 0, 0, 1, 0, 0);      outs("R5 read", 0, 1, 8'h33, 0);
    step(2'b10, 0, 0, 0, 1, 0, 0);      outs("R4 drain", 0, 0, 8'h33, 0);

    // held special character, read then reset
    step(2'b10, 1, 8'h44, 2'b10, 0, 0, 0); outs("R8 held irq", 1, 1, 8'h44, 0);
    step(2'b10, 0, 0, 0, 1, 0, 0);         outs("R8 read holds", 1, 1, 8'h44, 3'b010);
    step(2'b10, 0, 0, 0, 1, 0, 0);         outs("R8 reread", 1, 1, 8'h44, 3'b010);
    step(2'b10, 1, 8'h55, 0, 0, 0, 0);     outs("R8 queue", 1, 1, 8'h44, 3'b010);
    step(2'b10, 0, 0, 0, 0, 1, 3'b110);    outs("R9 release", 0, 1, 8'h55, 0);
    step(2'b10, 0, 0, 0, 1, 0, 0);         outs("R9 drain", 0, 0, 8'h55, 0);

    // special-only mode, discard without reading
    step(2'b11, 1, 8'h66, 2'b01, 0, 0, 0); outs("R8 spec held", 1, 1, 8'h66, 0);
    step(2'b11, 0, 0, 0, 0, 1, 3'b110);    outs("R9 lost", 0, 0, 8'h55, 0);
    step(2'b11, 1, 8'h77, 0, 0, 0, 0);     outs("R10 quiet", 0, 1, 8'h77, 0);
    step(2'b11, 0, 0, 0, 1, 0, 0);         outs("R10 drain", 0, 0, 8'h77, 0);

    // interrupts off
    step(2'b00, 1, 8'h88, 2'b01, 0, 0, 0); outs("R13 off", 0, 1, 8'h88, 0);
    step(2'b00, 0, 0, 0, 1, 0, 0);         outs("R13 read", 0, 0, 8'h88, 3'b001);
    step(2'b00, 0, 0, 0, 0, 1, 3'b111);    outs("R13 bad cmd", 0, 0, 8'h88, 3'b001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule